// File: doc/BRIEF.md
# Pseudorandom RAM Fill Engine

This block produces pseudorandom bytes from an 8-bit linear feedback shift register and writes them into an external 256 x 8 RAM in a single pass. A start request from idle begins a fill. The engine then steps the register once per clock. After every eighth step it writes the current register value to the next address, starting at 0x00. Because each byte is eight shifts apart from the previous one, consecutive bytes are not bit-shifted copies of each other.

After the byte for address 0xFF is written, the engine pulses a done flag and returns to idle. While idle the register holds its value, so a second fill carries on from where the first one stopped. A synchronous soft reset aborts any fill in progress and reloads the fixed nonzero seed. The next fill therefore repeats exactly the byte sequence produced after the previous reload. The write port of the RAM is driven directly: address, data and a one-cycle write enable.

Top module: `lfsr_fill_top`

## Requirements
- R1: After `rst_n` is released, and with no request yet, `ram_we` and `fill_done` are 0, `ram_addr` is 0x00 and `ram_wdata` equals the seed 0x01.
- R2: Each register step maps state s to {s[6:0], s[7]^s[5]^s[4]^s[3]}, with s[7] as the MSB. The state is never zero.
- R3: The first write of a fill occurs 8 clock edges after the edge that accepts `fill_start`. Each later write follows the previous one by exactly 8 edges. No write occurs in between.
- R4: The byte written to address k equals the state at the start of the fill advanced by 8*(k+1) steps.
- R5: A fill writes the addresses 0x00 to 0xFF once each, in ascending order. `ram_we` is high for exactly one cycle per address.
- R6: `fill_done` is high for exactly one cycle, the cycle right after the write to 0xFF. No write follows until a new request arrives.
- R7: A `fill_start` that is high while a fill is running, including during the final write cycle, has no effect on the addresses, timing or data of that fill.
- R8: `soft_rst` takes priority. On the next cycle `ram_we` and `fill_done` are 0, `ram_addr` is 0x00 and the state is the seed 0x01. A fill started after a reload writes the same 256 bytes as any other fill started after a reload.
- R9: In a fill started from the seed, bytes 0x00 to 0xFE are all distinct, and the byte at 0xFF equals the byte at 0x00 (period 255).
- R10: While idle the state, and so `ram_wdata`, holds. A fill started without a reload continues the sequence from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the seed |
| soft_rst | input | 1 | Synchronous reload of the seed; aborts a fill |
| fill_start | input | 1 | Request to start a fill; honoured only when idle |
| ram_addr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data (current register state) |
| ram_we | output | 1 | RAM write enable, one cycle per location |
| fill_done | output | 1 | One-cycle pulse after the last location is written |

## Verification
The bench watches the write enable on every cycle of each fill and aims at three boundaries: the first write, the final write to 0xFF together with the done pulse, and a request landing on that final write cycle. An off-by-one step counter would shift every write and would fail the 8-cycle spacing. A sequencer that obeys a late request would restart at 0x00 instead of pulsing done. Random soft resets part-way through a fill, followed by a full fill, catch a seed that is not reloaded or a sequence that differs between runs. The recorded first fill is also checked for 255 distinct bytes with wrap-around, which a wrong feedback tap would break.

// File: rtl/lfsr_fill_pkg.sv
package lfsr_fill_pkg;
    localparam int          LFSR_W         = 8;
    localparam int          ADDR_W         = 8;
    localparam int          STEPS_PER_BYTE = 8;
    // taps on bits 7,5,4,3 : x^8 + x^6 + x^5 + x^4 + 1
    localparam logic [LFSR_W-1:0] TAP_MASK = 8'hB8;
    localparam logic [LFSR_W-1:0] SEED     = 8'h01;

    typedef struct packed {
        logic              run;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              done;
    } seq_state_t;
endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
    parameter int              W     = 8,
    parameter logic [W-1:0]    TAPS  = 8'hB8,
    parameter logic [W-1:0]    SEED  = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state
);
    typedef struct packed {
        logic [W-1:0] sh;
    } core_t;

    core_t st_d, st_q;
    logic  fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.sh & TAPS);
        if (load) begin
            st_d.sh = SEED;
        end else if (step) begin
            st_d.sh = {st_q.sh[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: SEED};
        else        st_q <= st_d;
    end

    assign state = st_q.sh;

    // R2: all-zero lock-up state is never reached
    assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sh != '0);
    // R2: a step moves the low bits up by one place
    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> st_q.sh[W-1:1] == $past(st_q.sh[W-2:0]));
    // R10: the register holds when not stepped
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !load |=> $stable(st_q.sh));
    // R8: reload yields the seed
    assert_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.sh == SEED);
endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic wrap
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        wrap = en && !clear && (c_q.cnt == LAST);
        if (clear) begin
            c_d.cnt = '0;
        end else if (en) begin
            c_d.cnt = (c_q.cnt == LAST) ? '0 : c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R3: after a wrap the count starts again from zero
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> c_q.cnt == '0);
    // R3: no wrap is skipped or early: counting proceeds by one
    assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clear && !wrap |=> c_q.cnt == $past(c_q.cnt) + 1'b1);
endmodule

// File: rtl/fill_seq.sv
module fill_seq
    import lfsr_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              soft_rst,
    input  logic              wrap,
    output logic              step_en,
    output logic              cnt_clear,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              done
);
    seq_state_t s_d, s_q;
    logic       accept;
    logic       last_addr;

    always_comb begin
        s_d       = s_q;
        s_d.we    = 1'b0;
        s_d.done  = 1'b0;
        last_addr = (s_q.addr == '1);
        accept    = start && !s_q.run && !s_q.we;

        if (s_q.we) begin
            s_d.addr = s_q.addr + 1'b1;
            if (last_addr) s_d.done = 1'b1;
        end
        if (s_q.run && wrap) begin
            s_d.we = 1'b1;
            if (last_addr) s_d.run = 1'b0;
        end
        if (accept) begin
            s_d.run  = 1'b1;
            s_d.addr = '0;
        end
        if (soft_rst) begin
            s_d = '0;
        end

        step_en   = s_q.run && !soft_rst;
        cnt_clear = accept || soft_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;
    assign we   = s_q.we;
    assign done = s_q.done;

    // R5: enable lasts one cycle
    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.we |=> !s_q.we);
    // R5: address advances by one after each write
    assert_addr_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.we && !soft_rst |=> s_q.addr == $past(s_q.addr) + 1'b1);
    // R6: done only right after the write to the last location
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(s_q.we) && ($past(s_q.addr) == '1));
    // R6: no write in the done cycle
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.we && !s_q.run);
    // R7: a running fill keeps running until its last write
    assert_keep_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run && !soft_rst && !(wrap && last_addr) |=> s_q.run);
    // R7: a request during a fill leaves the address alone
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run && start && !s_q.we && !soft_rst |=> s_q.addr == $past(s_q.addr));
    // R8: soft reset clears the write side
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !s_q.we && !s_q.done && !s_q.run && s_q.addr == '0);
endmodule

// File: rtl/lfsr_fill_top.sv
module lfsr_fill_top
    import lfsr_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              fill_start,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [LFSR_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              fill_done
);
    logic step_en;
    logic cnt_clear;
    logic wrap;

    lfsr_core #(
        .W    (LFSR_W),
        .TAPS (TAP_MASK),
        .SEED (SEED)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (soft_rst),
        .step  (step_en),
        .state (ram_wdata)
    );

    step_counter #(
        .STEPS (STEPS_PER_BYTE)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .en    (step_en),
        .wrap  (wrap)
    );

    fill_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fill_start),
        .soft_rst  (soft_rst),
        .wrap      (wrap),
        .step_en   (step_en),
        .cnt_clear (cnt_clear),
        .addr      (ram_addr),
        .we        (ram_we),
        .done      (fill_done)
    );

    // R10: data is stable while no fill is running
    assert_idle_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en && !soft_rst |=> $stable(ram_wdata));
endmodule

// File: tb/sim_lfsr_fill_top.sv
module sim_lfsr_fill_top;
    localparam int CLK_PERIOD = 10;
    localparam int FILL_EDGES = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       fill_start = 1'b0;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       ram_we;
    logic       fill_done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model;
    logic [7:0] ref_fill [256];
    logic [7:0] cur_fill [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_fill_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .fill_start (fill_start),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .fill_done  (fill_done)
    );

    function automatic logic [7:0] step1(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [7:0] step8(input logic [7:0] s);
        logic [7:0] t = s;
        for (int i = 0; i < 8; i++) t = step1(t);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // checks the state right after a reload (R1 / R8)
    task automatic check_reset_state(input string req);
        check(ram_we == 1'b0, req, ram_we, 0);
        check(fill_done == 1'b0, req, fill_done, 0);
        check(ram_addr == 8'h00, req, ram_addr, 0);
        check(ram_wdata == 8'h01, req, ram_wdata, 8'h01);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(ram_wdata == model, "R10 idle hold", ram_wdata, model);
            check(ram_we == 1'b0, "R10 idle no write", ram_we, 0);
        end
    endtask

    task automatic do_reload();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        model = 8'h01;
        check_reset_state("R8 reload");
    endtask

    // poke: edge count at which a stray request is applied (-1 none)
    // abort: edge count at which soft reset is applied (-1 none)
    // mode: 0 none, 1 record reference, 2 compare to reference
    task automatic do_fill(input int poke, input int abort, input int mode);
        @(negedge clk);
        fill_start = 1'b1;
        @(negedge clk);
        fill_start = 1'b0;
        for (int c = 0; c <= FILL_EDGES + 3; c++) begin
            bit exp_we;
            bit exp_done;
            exp_we   = (c > 0) && (c % 8 == 0) && (c <= FILL_EDGES);
            exp_done = (c == FILL_EDGES + 1);
            check(ram_we == exp_we, "R3 write timing", ram_we, exp_we);
            check(fill_done == exp_done, "R6 done pulse", fill_done, exp_done);
            if (exp_we) begin
                int k;
                k = c / 8 - 1;
                model = step8(model);
                check(ram_addr == 8'(k), "R5 address order", ram_addr, k);
                check(ram_wdata == model, "R4 byte value (step rule R2)", ram_wdata, model);
                cur_fill[k] = ram_wdata;
                if (mode == 1) ref_fill[k] = ram_wdata;
                if (mode == 2)
                    check(ram_wdata == ref_fill[k], "R8 same sequence", ram_wdata, ref_fill[k]);
            end
            if (c == abort) begin
                soft_rst = 1'b1;
                @(negedge clk);
                soft_rst = 1'b0;
                model = 8'h01;
                check_reset_state("R8 abort");
                return;
            end
            fill_start = (c == poke);   // R7 stray request
            @(negedge clk);
            fill_start = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 reset");
        idle_cycles(5 + int'($urandom_range(0, 10)));

        // first fill from seed, recorded
        do_fill(-1, -1, 1);
        // R9 period: 255 distinct values then wrap
        check(ref_fill[255] == ref_fill[0], "R9 wrap", ref_fill[255], ref_fill[0]);
        begin
            int dup;
            dup = 0;
            for (int i = 0; i < 255; i++)
                for (int j = i + 1; j < 255; j++)
                    if (ref_fill[i] == ref_fill[j]) dup++;
            check(dup == 0, "R9 distinct", dup, 0);
        end

        // continuation without reload, stray request mid-fill
        idle_cycles(7);
        do_fill(100 + int'($urandom_range(0, 1800)), -1, 0);   // R10, R7

        // reload, request on last write cycle, compare sequence
        do_reload();
        do_fill(FILL_EDGES, -1, 2);                               // R7, R8

        // random aborts followed by full fills
        for (int r = 0; r < 3; r++) begin
            do_reload();
            do_fill(-1, 1 + int'($urandom_range(0, 2000)), 0);  // R8 abort
            idle_cycles(2);
            do_fill(int'($urandom_range(1, 2048)), -1, 2);
        end

        summary();
        $finish;
    end
endmodule